// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two independent guesses for every branch. The first is a per-branch saturating counter, found through the low bits of the branch address. The second is a counter picked by the address and by the pattern of the most recent branch outcomes. A per-branch 2-bit selector then decides which of the two guesses becomes the final answer. The selector drifts toward whichever component has been right more often lately.

A fetch stage presents a branch address on the predict side and receives the final direction in the same cycle. It also receives both component guesses, which it carries along with the branch. When the branch resolves, the pipeline returns the address, the real outcome and the two guesses it saw on the update side. The block then trains both counters, moves the selector if needed and shifts the outcome into the outcome history. Updates must arrive in program order, with no other update between a branch's prediction and its own update. The correlated lookup at update time reads the live history.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, every counter holds 1 (weakly not taken), every selector holds 1 (use the local guess) and the outcome history is all zeros. Every address therefore predicts not taken, with both component outputs at 0.
- R2: The local guess for address pc comes from entry pc[LOCAL_IDX_W-1:0]. Two addresses that agree in those bits share an entry.
- R3: Every direction counter is CTR_W bits wide and saturates at 0 and at its maximum. It predicts taken when its top bit is 1. A taken outcome adds one and a not-taken outcome subtracts one. With CTR_W=2, a counter at 3 needs two not-taken outcomes in a row before it predicts not taken.
- R4: Every update shifts the real outcome into bit 0 of the HIST_W-bit history, and older outcomes move one position up. Cycles without an update leave the history unchanged.
- R5: The correlated guess comes from entry {pc[CORR_PC_W-1:0], history}, with the history in the low bits. An update trains the entry selected by the history as it stands before that update's shift.
- R6: With HIST_W=0 and CTR_W=2, the correlated guess equals a plain 2-bit counter indexed by pc[CORR_PC_W-1:0].
- R7: The selector for address pc is entry pc[CHOOSE_IDX_W-1:0]. It is a 2-bit saturating counter. The final output takes the correlated guess when the selector is 2 or 3, and the local guess when it is 0 or 1.
- R8: On an update, the selector moves only if the two returned guesses differ. It moves up by one when the correlated guess matched the outcome and down by one otherwise, saturating at 0 and 3.
- R9: A prediction made in the same cycle as an update reflects the table and history contents from before that update.
- R10: The predict side also outputs the two component guesses, predLocal and predCorr, for the pipeline to return on update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| predPc | input | PC_W | Address of the branch being predicted |
| predTaken | output | 1 | Final direction, 1 = taken |
| predLocal | output | 1 | Local component guess |
| predCorr | output | 1 | Correlated component guess |
| updValid | input | 1 | A resolved branch is being reported this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Real outcome, 1 = taken |
| updLocalPred | input | 1 | Local guess returned from prediction time |
| updCorrPred | input | 1 | Correlated guess returned from prediction time |

## Verification
The hardest state to reach from the ports is a selector that has actually swung over to the correlated side. That only happens when the two components disagree repeatedly and the history-based counter keeps winning. The stimulus runs a group of three branches in which the third outcome is the exclusive-or of the first two. Only a history-aware counter can learn that relation, so the local counter keeps losing. Long pseudo-random address and outcome runs, nested-loop patterns and aliasing addresses are then compared step by step against an arithmetic model. A second instance with no history is checked against a plain per-address counter.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Strobes from the update control to the table datapath
  typedef struct packed {
    logic localWe;   // train local counter
    logic corrWe;    // train correlated counter
    logic chooseWe;  // move selector
    logic chooseUp;  // selector direction: toward correlated
    logic histShift; // shift outcome into history
    logic dirUp;     // direction counters count up
  } tp_strobe_t;
endpackage

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updLocalPred,
  input  logic       updCorrPred,
  output tp_strobe_t strobe
);
  logic disagree;
  logic corrRight;

  always_comb begin
    disagree  = updLocalPred ^ updCorrPred;
    corrRight = (updCorrPred == updTaken);
    strobe.localWe   = updValid;
    strobe.corrWe    = updValid;
    strobe.histShift = updValid;
    strobe.dirUp     = updTaken;
    strobe.chooseWe  = updValid & disagree;
    strobe.chooseUp  = corrRight;
  end
endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int PC_W         = 16,
  parameter int LOCAL_IDX_W  = 4,
  parameter int HIST_W       = 5,
  parameter int CORR_PC_W    = 2,
  parameter int CHOOSE_IDX_W = 4,
  parameter int CTR_W        = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  tp_strobe_t      strobe,
  output logic            predLocal,
  output logic            predCorr,
  output logic            predUseCorr
);
  localparam int HW         = (HIST_W > 0) ? HIST_W : 1;
  localparam int CORR_IDX_W = CORR_PC_W + HIST_W;
  localparam int LOCAL_N    = 1 << LOCAL_IDX_W;
  localparam int CORR_N     = 1 << CORR_IDX_W;
  localparam int CHOOSE_N   = 1 << CHOOSE_IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] localTab  [LOCAL_N];
  logic [CTR_W-1:0] corrTab   [CORR_N];
  logic [1:0]       chooseTab [CHOOSE_N];
  logic [HW-1:0]    histQ;

  logic [LOCAL_IDX_W-1:0]  predLocalIdx, updLocalIdx;
  logic [CORR_IDX_W-1:0]   predCorrIdx,  updCorrIdx;
  logic [CHOOSE_IDX_W-1:0] predChooseIdx, updChooseIdx;
  logic                    unusedPcBits;

  assign unusedPcBits  = ^{predPc, updPc, histQ};
  assign predLocalIdx  = predPc[LOCAL_IDX_W-1:0];
  assign updLocalIdx   = updPc[LOCAL_IDX_W-1:0];
  assign predChooseIdx = predPc[CHOOSE_IDX_W-1:0];
  assign updChooseIdx  = updPc[CHOOSE_IDX_W-1:0];

  generate
    if (HIST_W > 0) begin : g_hist
      assign predCorrIdx = {predPc[CORR_PC_W-1:0], histQ};
      assign updCorrIdx  = {updPc[CORR_PC_W-1:0], histQ};
    end else begin : g_nohist
      assign predCorrIdx = predPc[CORR_PC_W-1:0];
      assign updCorrIdx  = updPc[CORR_PC_W-1:0];
    end
  endgenerate

  function automatic logic [CTR_W-1:0] stepCtr(input logic [CTR_W-1:0] v, input logic up);
    if (up) return (v == CTR_MAX) ? v : v + 1'b1;
    else    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [1:0] stepSel(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    else    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  // Combinational lookups read the registered tables: same-cycle updates
  // are not visible until the next edge.
  assign predLocal   = localTab[predLocalIdx][CTR_W-1];
  assign predCorr    = corrTab[predCorrIdx][CTR_W-1];
  assign predUseCorr = chooseTab[predChooseIdx][1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LOCAL_N; i++) localTab[i] <= CTR_INIT;
    end else if (strobe.localWe) begin
      localTab[updLocalIdx] <= stepCtr(localTab[updLocalIdx], strobe.dirUp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CORR_N; i++) corrTab[i] <= CTR_INIT;
    end else if (strobe.corrWe) begin
      corrTab[updCorrIdx] <= stepCtr(corrTab[updCorrIdx], strobe.dirUp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CHOOSE_N; i++) chooseTab[i] <= 2'd1;
    end else if (strobe.chooseWe) begin
      chooseTab[updChooseIdx] <= stepSel(chooseTab[updChooseIdx], strobe.chooseUp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 histQ <= '0;
    else if (strobe.histShift) histQ <= HW'({histQ, updTaken});
  end

  // R4
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.histShift |=> histQ == HW'({$past(histQ), $past(updTaken)}));

  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.histShift |=> $stable(histQ));

  // R8
  chooser_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.localWe && !strobe.chooseWe) |=>
      chooseTab[$past(updChooseIdx)] == $past(chooseTab[updChooseIdx]));

  // R3
  local_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.localWe && strobe.dirUp && localTab[updLocalIdx] != CTR_MAX) |=>
      localTab[$past(updLocalIdx)] == CTR_W'($past(localTab[updLocalIdx]) + 1'b1));

  // R3
  local_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.localWe && !strobe.dirUp && localTab[updLocalIdx] != '0) |=>
      localTab[$past(updLocalIdx)] == CTR_W'($past(localTab[updLocalIdx]) - 1'b1));

  // R3
  local_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.localWe && strobe.dirUp && localTab[updLocalIdx] == CTR_MAX) |=>
      localTab[$past(updLocalIdx)] == CTR_MAX);
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W         = 16,
  parameter int LOCAL_IDX_W  = 4,
  parameter int HIST_W       = 5,
  parameter int CORR_PC_W    = 2,
  parameter int CHOOSE_IDX_W = 4,
  parameter int CTR_W        = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  output logic            predLocal,
  output logic            predCorr,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updLocalPred,
  input  logic            updCorrPred
);
  tp_strobe_t strobe;
  logic       useCorr;

  tp_ctrl u_ctrl (
    .updValid    (updValid),
    .updTaken    (updTaken),
    .updLocalPred(updLocalPred),
    .updCorrPred (updCorrPred),
    .strobe      (strobe)
  );

  tp_datapath #(
    .PC_W        (PC_W),
    .LOCAL_IDX_W (LOCAL_IDX_W),
    .HIST_W      (HIST_W),
    .CORR_PC_W   (CORR_PC_W),
    .CHOOSE_IDX_W(CHOOSE_IDX_W),
    .CTR_W       (CTR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .predPc     (predPc),
    .updPc      (updPc),
    .updTaken   (updTaken),
    .strobe     (strobe),
    .predLocal  (predLocal),
    .predCorr   (predCorr),
    .predUseCorr(useCorr)
  );

  // R7: selector top bit picks the correlated guess
  assign predTaken = useCorr ? predCorr : predLocal;
endmodule

// File: tb/tourney_predictor_tb.sv
module tourney_predictor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] predPc = '0;
  logic [PC_W-1:0] updPc = '0;
  logic            updValid = 1'b0, updTaken = 1'b0;
  logic            updLocalPred = 1'b0, updCorrPred = 1'b0;
  logic            predTaken, predLocal, predCorr;
  logic            p0Taken, p0Local, p0Corr;

  int checks = 0;
  int fails  = 0;

  int localM [16];
  int corrM  [128];
  int chooseM[16];
  int corr0M [4];
  int histM;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_predictor u_dut (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .predLocal(predLocal), .predCorr(predCorr), .updValid(updValid),
    .updPc(updPc), .updTaken(updTaken), .updLocalPred(updLocalPred),
    .updCorrPred(updCorrPred)
  );

  // History-free instance for R6
  tourney_predictor #(.HIST_W(0)) u_dut0 (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(p0Taken),
    .predLocal(p0Local), .predCorr(p0Corr), .updValid(updValid),
    .updPc(updPc), .updTaken(updTaken), .updLocalPred(updLocalPred),
    .updCorrPred(updCorrPred)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (pc=%0h t=%0t)", req, act, exp, predPc, $time);
    end
  endtask

  function automatic int sat(input int v, input int maxv, input bit up);
    if (up) return (v == maxv) ? v : v + 1;
    return (v == 0) ? v : v - 1;
  endfunction

  function automatic int lIdx(input int pc);  return pc % 16; endfunction
  function automatic int cIdx(input int pc);  return ((pc % 4) << 5) | histM; endfunction

  task automatic compareAll(input string tag, input int pc);
    int expL, expC, expT;
    expL = (localM[lIdx(pc)] >= 2);
    expC = (corrM[cIdx(pc)] >= 2);
    expT = (chooseM[pc % 16] >= 2) ? expC : expL;
    chk({tag, " R2 R10 local"}, predLocal, expL);
    chk({tag, " R5 R10 correlated"}, predCorr, expC);
    chk({tag, " R7 final"}, predTaken, expT);
    chk({tag, " R6 no-history correlated"}, p0Corr, (corr0M[pc % 4] >= 2));
  endtask

  task automatic step(input int pc, input bit tk);
    int li, ci, chi, eL, eC;
    @(negedge clk);
    predPc = PC_W'(pc);
    updValid = 1'b0;
    #1;
    compareAll("predict", pc);
    li = lIdx(pc); ci = cIdx(pc); chi = pc % 16;
    eL = (localM[li] >= 2); eC = (corrM[ci] >= 2);
    updPc = PC_W'(pc); updTaken = tk;
    updLocalPred = eL[0]; updCorrPred = eC[0];
    updValid = 1'b1;
    #1;
    compareAll("R9 same-cycle", pc);
    @(posedge clk);
    localM[li] = sat(localM[li], 3, tk);
    corrM[ci]  = sat(corrM[ci], 3, tk);
    corr0M[pc % 4] = sat(corr0M[pc % 4], 3, tk);
    if (eL != eC) chooseM[chi] = sat(chooseM[chi], 3, (eC == int'(tk)));
    histM = ((histM << 1) | int'(tk)) & 31;
    #1;
    updValid = 1'b0;
  endtask

  task automatic peekLocal(input int pc, input int exp, input string req);
    @(negedge clk);
    predPc = PC_W'(pc);
    #1;
    chk(req, predLocal, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    bit a, b;
    for (int i = 0; i < 16; i++) begin localM[i] = 1; chooseM[i] = 1; end
    for (int i = 0; i < 128; i++) corrM[i] = 1;
    for (int i = 0; i < 4; i++) corr0M[i] = 1;
    histM = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state, every address predicts not taken
    for (int pc = 0; pc < 16; pc++) begin
      @(negedge clk); predPc = PC_W'(pc); #1;
      chk("R1 reset final", predTaken, 0);
      chk("R1 reset local", predLocal, 0);
      chk("R1 reset correlated", predCorr, 0);
    end

    // R3: saturation and two-miss flip on address 3
    for (int i = 0; i < 5; i++) step(3, 1'b1);
    peekLocal(3, 1, "R3 saturated taken");
    step(3, 1'b0);
    peekLocal(3, 1, "R3 one miss keeps taken");
    step(3, 1'b0);
    peekLocal(3, 0, "R3 two misses flip");

    // R2: address 21 aliases onto local entry of address 5
    step(21, 1'b1);
    step(21, 1'b1);
    peekLocal(5, 1, "R2 alias shares entry");

    // Nested loop: inner branch taken 9 times then falls through
    for (int o = 0; o < 20; o++) begin
      for (int k = 0; k < 10; k++) step(16'h40, (k != 9));
      step(16'h44, 1'b1);
    end

    // R8: correlated trio, third outcome = first xor second
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[0]; b = lfsr[5];
      step(16'h1A, a);
      step(16'h1D, b);
      step(16'h1E, a ^ b);
    end
    // R8: selector for the xor branch must have swung to correlated
    chk("R8 selector learned correlated", (chooseM[14] >= 2), 1);

    // R4 R5: pseudo-random addresses and outcomes
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[7:0]), lfsr[9] | lfsr[11]);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule